// File: doc/BRIEF.md
# Epoch-Paced Page Write Regulator

This block stretches a fixed budget of page writes over a fixed number of epochs by holding back each page write for a programmable number of cycles. Every accepted write costs one page unit of the remaining budget. Time is cut into epochs of `EPOCH_LEN` cycles. At the end of each epoch the block takes the number of pages accepted in that epoch as the prediction for the next one, since it assumes the workload repeats once per epoch. It then divides the remaining budget by the number of epochs still to run, which gives the capacity of the coming epoch. Finally it moves the per-page delay up or down by one step, or leaves it as it is.

The delay is the same for every page write. After a write is accepted, the handshake stays not-ready until that many cycles have gone by, which keeps the gap between writes even. Configuration is sampled while the synchronous reset is held low. A bonus term is added to the budget at that point to credit the extra endurance gained from cell recovery. The division runs on a sequential divider over `BW` cycles, so a new delay is only used after the divider has finished.

Top module: `write_pacer`

## Requirements
- R1: While `rst_n` is low the block loads its configuration. After reset, `delay` equals min(`cfg_delay0`, `cfg_max`), `epoch_cap` is 0, `budget_left` is the saturated sum of R10, and `wr_ready` is 1.
- R2: `wr_ready` is 1 exactly when the hold counter is 0. An accepted write (`wr_valid` and `wr_ready` high at a clock edge) loads the counter with the current `delay`. Otherwise the counter counts down by one per cycle and stops at 0. This gives exactly `delay` not-ready cycles after every accepted write.
- R3: Each accepted write lowers `budget_left` by 1, with a floor of 0. In a cycle without an accepted write, `budget_left` does not change.
- R4: Edge number k·`EPOCH_LEN` after reset release closes an epoch, and a write accepted at that edge counts toward the closing epoch. The prediction is the number of writes accepted in the closing epoch. The capacity is `budget_left` after that edge divided by the remaining epoch count, where a count of 0 is treated as 1. `epoch_cap` shows the capacity `BW` edges after the closing edge.
- R5: If the prediction is larger than the capacity, `delay` rises by `cfg_step` and is clamped at `cfg_max`.
- R6: If the prediction is smaller than the capacity, `delay` falls by `cfg_step` and never goes below 0.
- R7: If the prediction equals the capacity, `delay` is left unchanged.
- R8: `delay` changes only at the edge where the divider finishes. A write accepted at that same edge still uses the old value.
- R9: The remaining epoch count starts at `cfg_epochs`. It is decremented when each division finishes, but never below 1, and a count of 0 stays at 0.
- R10: The initial budget is `cfg_budget + cfg_bonus`, saturated at 2^BW−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_budget | input | BW | Page writes allowed over the whole lifetime |
| cfg_bonus | input | BW | Extra pages credited for cell recovery |
| cfg_epochs | input | EW | Number of epochs the budget must cover |
| cfg_step | input | DW | Delay adjustment per epoch |
| cfg_max | input | DW | Upper clamp for the delay |
| cfg_delay0 | input | DW | Delay used before the first adjustment |
| wr_valid | input | 1 | Page write request |
| wr_ready | output | 1 | Page write may proceed this cycle |
| delay | output | DW | Current per-page delay in cycles |
| epoch_cap | output | BW | Capacity computed at the last epoch end |
| budget_left | output | BW | Remaining page budget |

## Verification
The bench targets the following corner cases:

- **Equal case.** A fixed per-epoch quota makes the prediction land exactly on the capacity in every epoch. A design that folds equality into the raise or lower branch would show the delay drifting.
- **Clamps.** Sustained heavy demand pushes the delay against `cfg_max`, and very light demand pushes it against 0. A design with a wrong clamp would wrap or overshoot.
- **Exhausted budget.** The budget is driven to zero, which checks that it saturates instead of wrapping to a huge value that would collapse the delay.
- **Boundary timing.** Writes accepted on the epoch-closing edge and on the divider-finish edge must be attributed to the right epoch and use the right delay. A design that is off by one cycle there would mismatch the per-cycle `wr_ready` trace.
- **Zero epoch count and overflowing bonus.** A design without the divide-by-one guard or without budget saturation would produce a wrong capacity.

// File: rtl/write_pacer.sv
module write_pacer #(
  parameter int BW        = 16,
  parameter int EW        = 8,
  parameter int DW        = 8,
  parameter int EPOCH_LEN = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cfg_budget,
  input  logic [BW-1:0] cfg_bonus,
  input  logic [EW-1:0] cfg_epochs,
  input  logic [DW-1:0] cfg_step,
  input  logic [DW-1:0] cfg_max,
  input  logic [DW-1:0] cfg_delay0,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [DW-1:0] delay,
  output logic [BW-1:0] epoch_cap,
  output logic [BW-1:0] budget_left
);
  localparam int ECW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
  localparam int ICW = $clog2(BW + 1);

  logic [DW-1:0]  step_q, max_q, hold_q;
  logic [EW-1:0]  epl_q;
  logic [ECW-1:0] ep_cnt;
  logic [BW-1:0]  wcnt_q, pred_q, rem_q, quo_q, dvs_q;
  logic [ICW-1:0] it_cnt;
  logic           busy;

  logic [BW:0]    init_sum;
  logic [BW-1:0]  init_bud, bud_n, wcnt_n, rem_n, quo_n;
  logic [BW:0]    shl, dvx;
  logic           acc, boundary, ge, done;
  logic [DW:0]    up;
  logic [DW-1:0]  up_c, dn_c, delay_n;

  assign init_sum = {1'b0, cfg_budget} + {1'b0, cfg_bonus};
  assign init_bud = init_sum[BW] ? '1 : init_sum[BW-1:0];

  assign wr_ready = (hold_q == '0);
  assign acc      = wr_valid & wr_ready;
  assign bud_n    = (acc && budget_left != '0) ? budget_left - 1'b1 : budget_left;
  assign wcnt_n   = wcnt_q + BW'(acc);
  assign boundary = (ep_cnt == ECW'(EPOCH_LEN - 1));

  assign shl   = {rem_q, quo_q[BW-1]};
  assign dvx   = {1'b0, dvs_q};
  assign ge    = (shl >= dvx);
  assign rem_n = ge ? BW'(shl - dvx) : shl[BW-1:0];
  assign quo_n = {quo_q[BW-2:0], ge};
  assign done  = busy && (it_cnt == ICW'(1));

  assign up   = {1'b0, delay} + {1'b0, step_q};
  assign up_c = (up > {1'b0, max_q}) ? max_q : up[DW-1:0];
  assign dn_c = (delay > step_q) ? delay - step_q : '0;

  always_comb begin
    if (pred_q > quo_n)      delay_n = up_c;
    else if (pred_q < quo_n) delay_n = dn_c;
    else                     delay_n = delay;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q      <= cfg_step;
      max_q       <= cfg_max;
      delay       <= (cfg_delay0 > cfg_max) ? cfg_max : cfg_delay0;
      epl_q       <= cfg_epochs;
      budget_left <= init_bud;
      epoch_cap   <= '0;
      hold_q      <= '0;
      ep_cnt      <= '0;
      wcnt_q      <= '0;
      pred_q      <= '0;
      rem_q       <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      it_cnt      <= '0;
      busy        <= 1'b0;
    end else begin
      budget_left <= bud_n;
      if (acc)                hold_q <= delay;
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;

      if (boundary) begin
        ep_cnt <= '0;
        wcnt_q <= '0;
        pred_q <= wcnt_n;
        quo_q  <= bud_n;
        rem_q  <= '0;
        dvs_q  <= (epl_q == '0) ? BW'(1) : BW'(epl_q);
        it_cnt <= ICW'(BW);
        busy   <= 1'b1;
      end else begin
        ep_cnt <= ep_cnt + 1'b1;
        wcnt_q <= wcnt_n;
        if (busy) begin
          rem_q  <= rem_n;
          quo_q  <= quo_n;
          it_cnt <= it_cnt - 1'b1;
          if (done) begin
            busy      <= 1'b0;
            epoch_cap <= quo_n;
            delay     <= delay_n;
            if (epl_q > EW'(1)) epl_q <= epl_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/write_pacer_chk.sv
module write_pacer_chk #(
  parameter int BW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] delay,
  input logic [DW-1:0] max_q,
  input logic [BW-1:0] budget_left,
  input logic          busy
);
  a_r2_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && delay != '0) |=> !wr_ready);

  a_r3_budget_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && budget_left != '0) |=> budget_left == $past(budget_left) - 1'b1);

  a_r3_budget_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(budget_left));

  a_r5_delay_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    delay <= max_q);

  a_r8_delay_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(delay));
endmodule

bind write_pacer write_pacer_chk #(.BW(BW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .delay(delay), .max_q(max_q), .budget_left(budget_left), .busy(busy));

// File: tb/write_pacer_tb.sv
module write_pacer_tb;
  localparam int BW = 16, EW = 8, DW = 6, L = 64;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [BW-1:0] cfg_budget = '0, cfg_bonus = '0;
  logic [EW-1:0] cfg_epochs = '0;
  logic [DW-1:0] cfg_step = '0, cfg_max = '0, cfg_delay0 = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [DW-1:0] delay;
  logic [BW-1:0] epoch_cap, budget_left;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  write_pacer #(.BW(BW), .EW(EW), .DW(DW), .EPOCH_LEN(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_budget(cfg_budget), .cfg_bonus(cfg_bonus),
    .cfg_epochs(cfg_epochs), .cfg_step(cfg_step), .cfg_max(cfg_max),
    .cfg_delay0(cfg_delay0), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .delay(delay), .epoch_cap(epoch_cap), .budget_left(budget_left));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint sat_sum(longint a, longint b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction

  function automatic longint next_delay(longint d, longint pred, longint cap,
                                        longint st, longint mx);
    if (pred > cap) return (d + st > mx) ? mx : d + st;
    if (pred < cap) return (d > st) ? d - st : 0;
    return d;
  endfunction

  task automatic run(input string tag, input int bud, input int bon, input int ep,
                     input int st, input int mx, input int d0, input int pct,
                     input int quota, input int n_ep);
    longint bm, dm, capm, capx, pred, wc, epl, hold, e;
    bit v;
    rst_n = 1'b0; wr_valid = 1'b0;
    cfg_budget = BW'(bud); cfg_bonus = BW'(bon); cfg_epochs = EW'(ep);
    cfg_step = DW'(st); cfg_max = DW'(mx); cfg_delay0 = DW'(d0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    bm = sat_sum(bud, bon); dm = (d0 > mx) ? mx : d0; capm = 0; capx = 0;
    pred = 0; wc = 0; epl = ep; hold = 0; e = 0;
    // R1 / R10: state straight after reset
    check({tag, " R1 delay"}, delay, dm);
    check({tag, " R1 cap"}, epoch_cap, 0);
    check({tag, " R10 budget"}, budget_left, bm);
    check({tag, " R1 ready"}, wr_ready, 1);
    while (e < longint'(n_ep) * L + L/2 + 1) begin
      check({tag, " R2 ready"}, wr_ready, hold == 0);
      if (e > 0 && e % L == L/2) begin
        check({tag, " R5/R6/R7 delay"}, delay, dm);
        check({tag, " R4/R9 cap"}, epoch_cap, capm);
        check({tag, " R3 budget"}, budget_left, bm);
      end
      v = (quota > 0) ? (wc < quota) : (($urandom % 100) < pct);
      wr_valid = v;
      @(posedge clk);
      e++;
      if (v && hold == 0) begin
        hold = dm;
        if (bm > 0) bm--;
        wc++;
      end else if (hold > 0) hold--;
      if (e % L == 0) begin
        pred = wc; wc = 0;
        capx = bm / ((epl == 0) ? 1 : epl);
      end
      if (e >= L && e % L == BW) begin   // R8: divider finish edge
        capm = capx;
        dm = next_delay(dm, pred, capx, st, mx);
        if (epl > 1) epl--;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    run("heavy",    300,  20, 10, 2,  9,  0, 90,  0, 8);
    run("light",   5000,   0,  4, 3, 20, 14, 20,  0, 8);
    run("equal",     50,   0,  4, 1, 10,  3,  0, 10, 4);
    run("drained",   40,   0,  2, 5, 31,  0, 100, 0, 4);
    run("satur",  65530, 100,  0, 4, 40, 50, 50,  0, 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule